// File: doc/BRIEF.md
# Clock Source Mode Transition Sequencer

This block steers a clock-generation unit from whatever operating mode it is in to a mode that a requester asks for. The unit has a frequency-locked loop, an internal slow reference, an external reference (optionally a crystal oscillator) and a low-power bit. These give six modes:

- loop on internal reference
- loop on external reference
- bypass on internal reference
- bypass on external reference
- the two bypass modes with low-power set

The sequencer reads the unit's status inputs to decode the present mode. A fixed routing table then picks the next legal intermediate mode. The sequencer drives the control fields for that step: reference select, output select, reference divider, bus divider and low-power. It waits for the matching status acknowledgements, and for oscillator-ready and loop lock where the step needs them. It then pulses the loss-of-lock clear. It repeats single steps until the target mode is reached.

A requester pulses `start` with a target mode and the two divider values. `busy` stays high while the sequence runs. It ends with a one-cycle `done` pulse, or a one-cycle `err` pulse carrying a 2-bit reason. Every wait is bounded by a programmable timeout, so a dead oscillator or a loop that never locks ends as an error rather than a hang. The oscillator and the loop themselves sit outside the block and are seen only through their status inputs.

Top module: `clkmode_seq`

## Requirements
- R1: The present mode is decoded from `out_stat`, `ref_stat` and the driven `low_pwr` bit, using the mode codes of R2:
  - `out_stat`=00 gives loop-external (code 3) when `ref_stat`=0, and loop-internal (code 0) when `ref_stat`=1.
  - `out_stat`=01 gives bypass-internal-low-power (2) when `low_pwr`=1, else bypass-internal (1).
  - `out_stat`=10 gives bypass-external-low-power (5) when `low_pwr`=1, else bypass-external (4).
  - `out_stat`=11 is an invalid state.
- R2: Mode codes are 0 loop-internal, 1 bypass-internal, 2 bypass-internal-low-power, 3 loop-external, 4 bypass-external and 5 bypass-external-low-power. Routing works as follows:
  - From code 2, every target other than 2 steps to 1 first; from code 5, every target other than 5 steps to 4 first.
  - Target 2 is reached via 1 unless the present mode is 1; target 5 is reached via 4 unless the present mode is 4.
  - All other moves among codes 0, 1, 3 and 4 are a single direct step.
  - Steps repeat until the step just finished equals the target.
- R3: A loop step (code 0 or 3) writes its controls in two writes:
  - code 0: reference select internal first, then output select 00 with the bus divider;
  - code 3: output 00, the reference divider and external reference together, then the bus divider.
  It then waits for the matching reference status, then `out_stat`=00, then `loop_lock`, and pulses `lol_clr` for one cycle.
- R4: A bypass step (code 1 or 4) first loads the bus divider and clears `low_pwr`. Code 1 then sets output 01 with the internal reference. Code 4 then sets output 10 with the external reference and the reference divider. It waits for the matching statuses without any lock wait, then pulses `lol_clr`.
- R5: A low-power step (code 2 or 5) only loads the bus divider and sets `low_pwr`. It is accepted only while `out_stat` is 01 (for code 2) or 10 (for code 5). It produces no `lol_clr` pulse.
- R6: On loop-external and bypass-external steps with `osc_sel`=1, the sequencer waits for `osc_ready` before the status waits.
- R7: A wait that is still unmet after `tmo_limit`+1 cycles aborts the sequence with `err` and `err_code`=2. Controls already written are kept.
- R8: If `out_stat`=11 when a step is planned, the sequence aborts with `err_code`=3 and the control outputs do not change.
- R9: A target code of 6 or 7, or a step that is not legal from the present mode, aborts with `err_code`=1. The control outputs do not change.
- R10: `busy` rises on the edge that accepts `start`. The result appears after 1 + Σ(9 per loop or bypass step, 3 per low-power step) edges, counting the accepting edge. An error detected at planning appears 2 edges after start. `done` and `err` are single-cycle and exclusive, and `busy` falls with them.
- R11: A `start` pulse while `busy` is high is ignored and does not change the running target.
- R12: After reset the controls are:
  - `sel_ref_int`=1, `sel_out`=00, `low_pwr`=0;
  - both dividers at 0;
  - `busy`, `done`, `err` and `lol_clr` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request pulse |
| tgt_mode | input | 3 | Requested mode code |
| bdiv_req | input | BDIV_W | Bus divider to load |
| rdiv_req | input | RDIV_W | Reference divider to load |
| osc_sel | input | 1 | External reference is a crystal oscillator needing ready |
| tmo_limit | input | TMO_W | Wait timeout limit in cycles |
| out_stat | input | 2 | Output clock status from the unit |
| ref_stat | input | 1 | Reference status, 1 = internal |
| osc_ready | input | 1 | Oscillator ready flag |
| loop_lock | input | 1 | Loop lock flag |
| sel_ref_int | output | 1 | Reference select, 1 = internal |
| sel_out | output | 2 | Output clock select |
| ref_div | output | RDIV_W | Reference divider control |
| bus_div | output | BDIV_W | Bus divider control |
| low_pwr | output | 1 | Low-power control |
| lol_clr | output | 1 | One-cycle loss-of-lock sticky clear |
| busy | output | 1 | Sequence running |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle failure pulse |
| err_code | output | 2 | 1 unreachable, 2 timeout, 3 invalid state |

## Verification
The bench's behavioural model walks the routing rules to build the list of steps. From that list it derives the due edge of the final pulse: nine edges per loop or bypass step, three per low-power step, one for accepting the request, and two in total for planning-time errors. Timeouts add `tmo_limit`+1 edges in the stuck wait. On every clock from the accepting edge onward, the bench compares `busy`, `done` and `err` with the value due after that edge. It samples on the falling edge, so each registered output is read half a period after the edge that set it. The `lol_clr` pulses are counted against the model's step count, and the control fields are compared with the model once the sequence has ended.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    LOOP_INT   = 3'd0,
    BYP_INT    = 3'd1,
    BYP_INT_LP = 3'd2,
    LOOP_EXT   = 3'd3,
    BYP_EXT    = 3'd4,
    BYP_EXT_LP = 3'd5,
    MODE_BAD   = 3'd7
  } mode_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PLAN, S_WR1, S_WR2, S_WOSC, S_WREF, S_WOUT, S_WLOCK, S_CLR, S_END
  } seq_st_e;

  localparam logic [1:0] EC_NONE     = 2'd0;
  localparam logic [1:0] EC_UNREACH  = 2'd1;
  localparam logic [1:0] EC_TIMEOUT  = 2'd2;
  localparam logic [1:0] EC_BADSTATE = 2'd3;

  // Next single step from cur toward tgt; MODE_BAD for codes outside the six modes.
  function automatic logic [MODE_W-1:0] route_fn(int c, int t);
    if (c > 5 || t > 5) return MODE_BAD;
    if (c == 2) return (t == 2) ? 3'd2 : 3'd1;
    if (c == 5) return (t == 5) ? 3'd5 : 3'd4;
    if (t == 2) return (c == 1) ? 3'd2 : 3'd1;
    if (t == 5) return (c == 4) ? 3'd5 : 3'd4;
    return t[MODE_W-1:0];
  endfunction

  // Whether entering stp is permitted from cur with the given output status.
  function automatic logic step_legal(mode_e cur, mode_e stp, logic [1:0] os);
    logic ok;
    case (stp)
      LOOP_INT, LOOP_EXT: ok = (cur inside {LOOP_INT, BYP_INT, LOOP_EXT, BYP_EXT});
      BYP_INT:            ok = (cur inside {LOOP_INT, BYP_INT, LOOP_EXT, BYP_EXT, BYP_INT_LP});
      BYP_EXT:            ok = (cur inside {LOOP_INT, BYP_INT, LOOP_EXT, BYP_EXT, BYP_EXT_LP});
      BYP_INT_LP:         ok = (os == 2'b01);
      BYP_EXT_LP:         ok = (os == 2'b10);
      default:            ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/clkmode_decode.sv
module clkmode_decode
  import clkmode_pkg::*;
(
  input  logic [1:0] out_stat,
  input  logic       ref_stat,
  input  logic       low_pwr,
  output mode_e      mode
);
  always_comb begin
    case (out_stat)
      2'b00:   mode = ref_stat ? LOOP_INT : LOOP_EXT;
      2'b01:   mode = low_pwr ? BYP_INT_LP : BYP_INT;
      2'b10:   mode = low_pwr ? BYP_EXT_LP : BYP_EXT;
      default: mode = MODE_BAD;
    endcase
  end
endmodule

// File: rtl/clkmode_route.sv
module clkmode_route
  import clkmode_pkg::*;
(
  input  mode_e cur,
  input  mode_e tgt,
  output mode_e nxt
);
  localparam int N   = 1 << MODE_W;
  localparam int IDX = 2 * MODE_W;

  logic [MODE_W-1:0] tbl [N*N];
  logic [IDX-1:0]    sel;

  for (genvar gc = 0; gc < N; gc++) begin : g_cur
    for (genvar gt = 0; gt < N; gt++) begin : g_tgt
      assign tbl[gc*N + gt] = route_fn(gc, gt);
    end
  end

  assign sel = {cur, tgt};
  assign nxt = mode_e'(tbl[sel]);
endmodule

// File: rtl/clkmode_tmo.sv
module clkmode_tmo #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en)          cnt <= '0;
    else if (cnt != limit)   cnt <= cnt + 1'b1;
  end

  assign expired = en && (cnt == limit);
endmodule

// File: rtl/clkmode_seq.sv
module clkmode_seq
  import clkmode_pkg::*;
#(
  parameter int BDIV_W = 3,
  parameter int RDIV_W = 3,
  parameter int TMO_W  = 16,
  parameter bit CHECK_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        tgt_mode,
  input  logic [BDIV_W-1:0] bdiv_req,
  input  logic [RDIV_W-1:0] rdiv_req,
  input  logic              osc_sel,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic [1:0]        out_stat,
  input  logic              ref_stat,
  input  logic              osc_ready,
  input  logic              loop_lock,
  output logic              sel_ref_int,
  output logic [1:0]        sel_out,
  output logic [RDIV_W-1:0] ref_div,
  output logic [BDIV_W-1:0] bus_div,
  output logic              low_pwr,
  output logic              lol_clr,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_code
);
  localparam logic [2:0] LAST_MODE = 3'd5;

  seq_st_e           st;
  mode_e             cur_mode, route_nxt, step_q;
  logic [2:0]        tgt_q;
  logic [BDIV_W-1:0] bdiv_q;
  logic [RDIV_W-1:0] rdiv_q;
  logic              need_osc, need_lock, exp_ref, wait_ok, in_wait, tmo_en, tmo_exp;
  logic [1:0]        exp_out;

  clkmode_decode u_dec (
    .out_stat (out_stat),
    .ref_stat (ref_stat),
    .low_pwr  (low_pwr),
    .mode     (cur_mode)
  );

  clkmode_route u_rte (
    .cur (cur_mode),
    .tgt (mode_e'(tgt_q)),
    .nxt (route_nxt)
  );

  clkmode_tmo #(.TMO_W(TMO_W)) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .en      (tmo_en),
    .limit   (tmo_limit),
    .expired (tmo_exp)
  );

  // Per-step expectations
  always_comb begin
    need_osc  = osc_sel && (step_q == LOOP_EXT || step_q == BYP_EXT);
    need_lock = (step_q == LOOP_INT || step_q == LOOP_EXT);
    exp_ref   = (step_q == LOOP_INT || step_q == BYP_INT);
    case (step_q)
      BYP_INT: exp_out = 2'b01;
      BYP_EXT: exp_out = 2'b10;
      default: exp_out = 2'b00;
    endcase
  end

  always_comb begin
    in_wait = 1'b1;
    case (st)
      S_WOSC:  wait_ok = !need_osc || osc_ready;
      S_WREF:  wait_ok = (ref_stat == exp_ref);
      S_WOUT:  wait_ok = (out_stat == exp_out);
      S_WLOCK: wait_ok = !need_lock || loop_lock;
      default: begin wait_ok = 1'b1; in_wait = 1'b0; end
    endcase
    tmo_en = in_wait && !wait_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      step_q      <= LOOP_INT;
      tgt_q       <= '0;
      bdiv_q      <= '0;
      rdiv_q      <= '0;
      sel_ref_int <= 1'b1;
      sel_out     <= 2'b00;
      ref_div     <= '0;
      bus_div     <= '0;
      low_pwr     <= 1'b0;
      lol_clr     <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
      err         <= 1'b0;
      err_code    <= EC_NONE;
    end else begin
      lol_clr <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            tgt_q  <= tgt_mode;
            bdiv_q <= bdiv_req;
            rdiv_q <= rdiv_req;
            busy   <= 1'b1;
            st     <= S_PLAN;
          end
        end
        S_PLAN: begin
          if (tgt_q > LAST_MODE) begin
            err <= 1'b1; err_code <= EC_UNREACH; busy <= 1'b0; st <= S_IDLE;
          end else if (cur_mode == MODE_BAD) begin
            err <= 1'b1; err_code <= EC_BADSTATE; busy <= 1'b0; st <= S_IDLE;
          end else if (CHECK_EN && !step_legal(cur_mode, route_nxt, out_stat)) begin
            err <= 1'b1; err_code <= EC_UNREACH; busy <= 1'b0; st <= S_IDLE;
          end else begin
            step_q <= route_nxt;
            st     <= S_WR1;
          end
        end
        S_WR1: begin
          st <= S_WR2;
          case (step_q)
            LOOP_INT: sel_ref_int <= 1'b1;
            LOOP_EXT: begin
              sel_out <= 2'b00; ref_div <= rdiv_q; sel_ref_int <= 1'b0;
            end
            BYP_INT, BYP_EXT: begin
              bus_div <= bdiv_q; low_pwr <= 1'b0;
            end
            default: begin
              bus_div <= bdiv_q; low_pwr <= 1'b1; st <= S_END;
            end
          endcase
        end
        S_WR2: begin
          st <= S_WOSC;
          case (step_q)
            LOOP_INT: begin sel_out <= 2'b00; bus_div <= bdiv_q; end
            LOOP_EXT: bus_div <= bdiv_q;
            BYP_INT:  begin sel_out <= 2'b01; sel_ref_int <= 1'b1; end
            default: begin
              sel_out <= 2'b10; ref_div <= rdiv_q; sel_ref_int <= 1'b0;
            end
          endcase
        end
        S_WOSC, S_WREF, S_WOUT, S_WLOCK: begin
          if (wait_ok) begin
            case (st)
              S_WOSC:  st <= S_WREF;
              S_WREF:  st <= S_WOUT;
              S_WOUT:  st <= S_WLOCK;
              default: st <= S_CLR;
            endcase
          end else if (tmo_exp) begin
            err <= 1'b1; err_code <= EC_TIMEOUT; busy <= 1'b0; st <= S_IDLE;
          end
        end
        S_CLR: begin
          lol_clr <= 1'b1;
          st      <= S_END;
        end
        S_END: begin
          if (step_q == mode_e'(tgt_q)) begin
            done <= 1'b1; err_code <= EC_NONE; busy <= 1'b0; st <= S_IDLE;
          end else begin
            st <= S_PLAN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clkmode_seq_chk.sv
module clkmode_seq_chk #(
  parameter int BDIV_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [1:0]        err_code,
  input logic              lol_clr,
  input logic              low_pwr,
  input logic [1:0]        out_stat,
  input logic [1:0]        sel_out,
  input logic              sel_ref_int,
  input logic [BDIV_W-1:0] bus_div
);
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst) !(done && err)); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R10
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy); // R10
  AST_LOL_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst) lol_clr |-> busy); // R3
  AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (rst) err |-> (err_code != 2'b00)); // R7
  AST_LP_LEGAL: assert property (@(posedge clk) disable iff (rst)
    $rose(low_pwr) |-> ($past(out_stat) == 2'b01 || $past(out_stat) == 2'b10)); // R5
  AST_BADSTATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (err && err_code == 2'b11) |-> ($stable(sel_out) && $stable(sel_ref_int) && $stable(bus_div))); // R8
endmodule

bind clkmode_seq clkmode_seq_chk #(.BDIV_W(BDIV_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .err         (err),
  .err_code    (err_code),
  .lol_clr     (lol_clr),
  .low_pwr     (low_pwr),
  .out_stat    (out_stat),
  .sel_out     (sel_out),
  .sel_ref_int (sel_ref_int),
  .bus_div     (bus_div)
);

// File: tb/sim_clkmode_seq.sv
module sim_clkmode_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [2:0] tgt_mode = '0, bdiv_req = '0, rdiv_req = '0;
  logic       osc_sel = 1'b0, osc_ready = 1'b1, loop_lock = 1'b1, ovr_bad = 1'b0;
  logic [15:0] tmo_limit = 16'd5;
  logic [1:0] out_stat;
  logic       ref_stat;
  logic       sel_ref_int, low_pwr, lol_clr, busy, done, err;
  logic [1:0] sel_out, err_code;
  logic [2:0] ref_div, bus_div;

  int n_chk = 0, n_fail = 0;
  int m_out = 0, m_ref = 1, m_lp = 0, m_bd = 0, m_rd = 0;

  always #4 clk = ~clk;

  // Plant: status follows the controls at once unless forced invalid
  assign out_stat = ovr_bad ? 2'b11 : sel_out;
  assign ref_stat = sel_ref_int;

  clkmode_seq u0 (
    .clk(clk), .rst(rst), .start(start), .tgt_mode(tgt_mode), .bdiv_req(bdiv_req),
    .rdiv_req(rdiv_req), .osc_sel(osc_sel), .tmo_limit(tmo_limit), .out_stat(out_stat),
    .ref_stat(ref_stat), .osc_ready(osc_ready), .loop_lock(loop_lock),
    .sel_ref_int(sel_ref_int), .sel_out(sel_out), .ref_div(ref_div), .bus_div(bus_div),
    .low_pwr(low_pwr), .lol_clr(lol_clr), .busy(busy), .done(done), .err(err),
    .err_code(err_code)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int cur_of();
    if (m_out == 0) return m_ref ? 0 : 3;
    if (m_out == 1) return m_lp ? 2 : 1;
    return m_lp ? 5 : 4;
  endfunction

  function automatic int step_to(int c, int t);
    if (c == 2) return (t == 2) ? 2 : 1;
    if (c == 5) return (t == 5) ? 5 : 4;
    if (t == 2) return (c == 1) ? 2 : 1;
    if (t == 5) return (c == 4) ? 5 : 4;
    return t;
  endfunction

  task automatic apply_step(input int s, input int bd, input int rd);
    m_bd = bd;
    case (s)
      0: begin m_ref = 1; m_out = 0; end
      3: begin m_ref = 0; m_out = 0; m_rd = rd; end
      1: begin m_lp = 0; m_out = 1; m_ref = 1; end
      4: begin m_lp = 0; m_out = 2; m_ref = 0; m_rd = rd; end
      default: m_lp = 1;
    endcase
  endtask

  task automatic plan(input int tgt, input int bd, input int rd, output int lat, output int lol);
    int c = cur_of();
    int s;
    lat = 1; lol = 0;
    do begin
      s = step_to(c, tgt);
      apply_step(s, bd, rd);
      if (s == 2 || s == 5) lat += 3;
      else begin lat += 9; lol++; end
      c = s;
    end while (c != tgt);
  endtask

  task automatic do_run(input int tgt, input int bd, input int rd, input int code,
                        input int lat, input int lol, input string req, input int poke_k);
    int seen = 0;
    @(negedge clk);
    start = 1'b1; tgt_mode = tgt[2:0]; bdiv_req = bd[2:0]; rdiv_req = rd[2:0];
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= lat + 1; k++) begin
      chk(req, "busy", int'(busy), int'(k < lat));
      chk(req, "done", int'(done), int'(k == lat && code == 0));
      chk(req, "err", int'(err), int'(k == lat && code != 0));
      if (k == lat && code != 0) chk(req, "err_code", int'(err_code), code);
      if (lol_clr) seen++;
      if (k == poke_k) begin start = 1'b1; tgt_mode = 3'd0; bdiv_req = 3'd7; end
      else start = 1'b0;
      @(negedge clk);
    end
    chk(req, "lol_clr pulses", seen, lol);
    chk(req, "sel_out", int'(sel_out), m_out);
    chk(req, "sel_ref_int", int'(sel_ref_int), m_ref);
    chk(req, "low_pwr", int'(low_pwr), m_lp);
    chk(req, "bus_div", int'(bus_div), m_bd);
    chk(req, "ref_div", int'(ref_div), m_rd);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    int lat, lol;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12", "busy", int'(busy), 0);
    chk("R12", "done/err", int'(done | err | lol_clr), 0);
    chk("R12", "sel_out", int'(sel_out), 0);
    chk("R12", "sel_ref_int", int'(sel_ref_int), 1);
    chk("R12", "low_pwr", int'(low_pwr), 0);
    chk("R12", "dividers", int'(bus_div) + int'(ref_div), 0);

    // R3 R10: loop-internal to itself runs its entry once
    plan(0, 2, 0, lat, lol); do_run(0, 2, 0, 0, lat, lol, "R3", 0);
    // R2 R5: via bypass-external into its low-power form
    plan(5, 3, 5, lat, lol); do_run(5, 3, 5, 0, lat, lol, "R2", 0);
    // R2 R4: low-power external to low-power internal through both bypass modes
    plan(2, 4, 5, lat, lol); do_run(2, 4, 5, 0, lat, lol, "R2", 0);
    // R1 R3: low-power internal to loop-external
    plan(3, 1, 2, lat, lol); do_run(3, 1, 2, 0, lat, lol, "R1", 0);
    // R4: direct loop-external to bypass-external
    plan(4, 0, 3, lat, lol); do_run(4, 0, 3, 0, lat, lol, "R4", 0);
    // R7: loop never locks, timeout in lock wait after limit+1 cycles
    loop_lock = 1'b0;
    apply_step(0, 6, 0); do_run(0, 6, 0, 2, 13, 0, "R7", 0);
    loop_lock = 1'b1;
    plan(0, 6, 0, lat, lol); do_run(0, 6, 0, 0, lat, lol, "R7", 0);
    // R6: oscillator never ready, timeout in the oscillator wait
    osc_sel = 1'b1; osc_ready = 1'b0;
    apply_step(3, 2, 4); do_run(3, 2, 4, 2, 10, 0, "R6", 0);
    osc_ready = 1'b1;
    plan(3, 2, 4, lat, lol); do_run(3, 2, 4, 0, lat, lol, "R6", 0);
    osc_sel = 1'b0;
    // R9: target code 6 rejected, controls untouched
    do_run(6, 7, 7, 1, 2, 0, "R9", 0);
    // R8: invalid output status at planning
    ovr_bad = 1'b1;
    do_run(1, 7, 7, 3, 2, 0, "R8", 0);
    ovr_bad = 1'b0;
    // R11: start during busy with another target is ignored
    plan(1, 5, 1, lat, lol); do_run(1, 5, 1, 0, lat, lol, "R11", 3);
    // R5: enter low-power internal, then request it again
    plan(2, 3, 1, lat, lol); do_run(2, 3, 1, 0, lat, lol, "R5", 0);
    plan(2, 1, 1, lat, lol); do_run(2, 1, 1, 0, lat, lol, "R5", 0);
    chk("R10", "latency of repeated low-power entry", lat, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule